// File: doc/BRIEF.md
# Registered Command Buffer with Delayed Parity Check

This block sits between a memory controller and the DRAM devices of a registered memory module. On each rising clock edge it captures the address/command bus, the two clock-enable lines, the two on-die-termination lines and the chip-select lines. It then drives the captured values from registers onto two output copies, side A and side B, so that each copy can load half of the devices.

A mode input sets how the chip selects are routed. In pair mode only two chip-select inputs are used, and each one drives one output on side A and one on side B. In quad mode four chip-select inputs pass one to one to four outputs.

The block also guards the address/command bus with even parity. The controller sends the parity bit for a command one clock after the command itself. The block compares that bit against the XOR of the captured address/command bits. On a mismatch it pulls an active-low error output low for one cycle. A command is checked only when it selects at least one device.

Top module: `cmd_regbuf`

## Requirements
- R1: Address/command, clock-enable and termination inputs sampled at a rising edge appear on the outputs after that edge and hold until the next edge.
- R2: Side A and side B outputs for address/command, clock enable and termination always carry the same captured value.
- R3: With `pair_mode` = 1, chip-select input bit 0 drives output bits 0 (side A) and 2 (side B), and input bit 1 drives output bits 1 (side A) and 3 (side B). Chip-select input bits 3:2 have no effect on the outputs or on the parity check.
- R4: With `pair_mode` = 0, chip-select output bit i follows chip-select input bit i for i = 0..3.
- R5: The XOR of the address/command bits captured at edge N is compared with `par_in` sampled at edge N+1. On a mismatch, `err_n` is 0 in the cycle after edge N+1.
- R6: `err_n` is low for exactly one cycle per mismatch. It stays low into a further cycle only if the next command also mismatches.
- R7: No comparison is made for a command in which no active chip select (after mode masking) is low. For such a command, `err_n` stays 1 whatever `par_in` is.
- R8: Clock-enable, termination and chip-select values do not enter the parity computation.
- R9: A synchronous active-high `rst` drives the outputs to these values: chip selects all 1, clock enables 0, termination 0, address/command 0, `err_n` 1. No comparison is made at the first edge after `rst` is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| pair_mode | input | 1 | 1: two chip selects duplicated to both sides; 0: four chip selects one to one |
| ac_in | input | AC_W | Address/command bus |
| cke_in | input | 2 | Clock-enable inputs |
| odt_in | input | 2 | On-die-termination inputs |
| cs_n_in | input | 4 | Chip-select inputs, active low |
| par_in | input | 1 | Even parity for the previous cycle's address/command |
| ac_a | output | AC_W | Side A address/command |
| ac_b | output | AC_W | Side B address/command |
| cke_a | output | 2 | Side A clock enables |
| cke_b | output | 2 | Side B clock enables |
| odt_a | output | 2 | Side A termination |
| odt_b | output | 2 | Side B termination |
| cs_n_out | output | 4 | Routed chip selects, active low |
| err_n | output | 1 | Parity error, active low, one cycle per mismatch |

## Verification
A wrong chip-select routing or a stale side register shows on the outputs one edge after the offending input. The bench catches it on the very next sample. If the pending-check flag or the parity pipeline is corrupted, the error pulse moves by one cycle, or appears for an unselected command, or fails to appear for a selected one. Such faults are visible two edges after the command. A reset that fails to clear the pending-check flag shows as a false error at the first edge after release.

// File: rtl/cmd_regbuf_pkg.sv
package cmd_regbuf_pkg;
  localparam int CS_MAX  = 4;
  localparam int N_SIDES = 2;
  localparam int CTL_W   = 2;
  localparam logic CS_IDLE  = 1'b1;
  localparam logic CKE_IDLE = 1'b0;
  localparam logic ODT_IDLE = 1'b0;

  // even parity over a bus of any width: low bit of the sum equals the XOR
  function automatic logic bus_parity(input logic [63:0] bus, input int width);
    logic p;
    p = 1'b0;
    for (int i = 0; i < width; i++) p = p ^ bus[i];
    return p;
  endfunction
endpackage

// File: rtl/cs_route.sv
module cs_route
  import cmd_regbuf_pkg::*;
(
  input  logic              pair_mode,
  input  logic [CS_MAX-1:0] cs_n_in,
  output logic [CS_MAX-1:0] cs_n_lane,
  output logic              any_sel
);
  localparam int PAIR_N = CS_MAX / N_SIDES;

  for (genvar g = 0; g < CS_MAX; g++) begin : g_lane
    always_comb cs_n_lane[g] = pair_mode ? cs_n_in[g % PAIR_N] : cs_n_in[g];
  end

  always_comb any_sel = pair_mode ? ~(&cs_n_in[PAIR_N-1:0]) : ~(&cs_n_in);

  always_comb begin
    assert (!(pair_mode && !any_sel) || (cs_n_lane == '1))
      else $error("p_pair_idle_r3 failed");
  end
endmodule

// File: rtl/side_reg.sv
module side_reg
  import cmd_regbuf_pkg::*;
#(
  parameter int AC_W = 22
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [AC_W-1:0]  ac_d,
  input  logic [CTL_W-1:0] cke_d,
  input  logic [CTL_W-1:0] odt_d,
  output logic [AC_W-1:0]  ac_q,
  output logic [CTL_W-1:0] cke_q,
  output logic [CTL_W-1:0] odt_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ac_q  <= '0;
      cke_q <= {CTL_W{CKE_IDLE}};
      odt_q <= {CTL_W{ODT_IDLE}};
    end else begin
      ac_q  <= ac_d;
      cke_q <= cke_d;
      odt_q <= odt_d;
    end
  end

  p_capture_r1: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (ac_q == $past(ac_d)) && (cke_q == $past(cke_d)) && (odt_q == $past(odt_d)))
    else $error("p_capture_r1");
endmodule

// File: rtl/par_check.sv
module par_check
  import cmd_regbuf_pkg::*;
#(
  parameter int AC_W = 22
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [AC_W-1:0] ac_in,
  input  logic            any_sel,
  input  logic            par_in,
  output logic            err_n
);
  logic par_q;
  logic chk_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      par_q <= 1'b0;
      chk_q <= 1'b0;
      err_n <= 1'b1;
    end else begin
      par_q <= bus_parity(64'(ac_in), AC_W);
      chk_q <= any_sel;
      err_n <= ~(chk_q && (par_q != par_in));
    end
  end

  p_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    !chk_q |=> err_n) else $error("p_quiet_r7");
  p_cause_r5: assert property (@(posedge clk) disable iff (rst)
    !err_n |-> $past(chk_q)) else $error("p_cause_r5");
endmodule

// File: rtl/cmd_regbuf.sv
module cmd_regbuf
  import cmd_regbuf_pkg::*;
#(
  parameter int AC_W = 22
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pair_mode,
  input  logic [AC_W-1:0]   ac_in,
  input  logic [CTL_W-1:0]  cke_in,
  input  logic [CTL_W-1:0]  odt_in,
  input  logic [CS_MAX-1:0] cs_n_in,
  input  logic              par_in,
  output logic [AC_W-1:0]   ac_a,
  output logic [AC_W-1:0]   ac_b,
  output logic [CTL_W-1:0]  cke_a,
  output logic [CTL_W-1:0]  cke_b,
  output logic [CTL_W-1:0]  odt_a,
  output logic [CTL_W-1:0]  odt_b,
  output logic [CS_MAX-1:0] cs_n_out,
  output logic              err_n
);
  logic [AC_W-1:0]   side_ac  [N_SIDES];
  logic [CTL_W-1:0]  side_cke [N_SIDES];
  logic [CTL_W-1:0]  side_odt [N_SIDES];
  logic [CS_MAX-1:0] cs_lane;
  logic              any_sel;

  for (genvar s = 0; s < N_SIDES; s++) begin : g_side
    side_reg #(.AC_W(AC_W)) side_i (
      .clk(clk), .rst(rst), .ac_d(ac_in), .cke_d(cke_in), .odt_d(odt_in),
      .ac_q(side_ac[s]), .cke_q(side_cke[s]), .odt_q(side_odt[s])
    );
  end

  assign ac_a  = side_ac[0];
  assign ac_b  = side_ac[1];
  assign cke_a = side_cke[0];
  assign cke_b = side_cke[1];
  assign odt_a = side_odt[0];
  assign odt_b = side_odt[1];

  cs_route route_i (
    .pair_mode(pair_mode), .cs_n_in(cs_n_in), .cs_n_lane(cs_lane), .any_sel(any_sel)
  );

  always_ff @(posedge clk) begin
    if (rst) cs_n_out <= {CS_MAX{CS_IDLE}};
    else     cs_n_out <= cs_lane;
  end

  par_check #(.AC_W(AC_W)) chk_i (
    .clk(clk), .rst(rst), .ac_in(ac_in), .any_sel(any_sel), .par_in(par_in), .err_n(err_n)
  );

  p_sides_r2: assert property (@(posedge clk) disable iff (rst)
    (ac_a == ac_b) && (cke_a == cke_b) && (odt_a == odt_b)) else $error("p_sides_r2");
  p_pair_dup_r3: assert property (@(posedge clk) disable iff (rst)
    pair_mode |=> cs_n_out[3:2] == cs_n_out[1:0]) else $error("p_pair_dup_r3");
  p_quad_r4: assert property (@(posedge clk) disable iff (rst)
    !pair_mode |=> cs_n_out == $past(cs_n_in)) else $error("p_quad_r4");
  p_reset_r9: assert property (@(posedge clk)
    rst |=> (cs_n_out == '1) && (cke_a == '0) && (odt_a == '0) && err_n)
    else $error("p_reset_r9");
endmodule

// File: tb/cmd_regbuf_tb_top.sv
module cmd_regbuf_tb_top;
  localparam int PERIOD = 10;
  localparam int AC_W = 22;
  localparam int NV = 8;

  typedef struct packed {
    logic            mode;
    logic [3:0]      cs;
    logic [AC_W-1:0] ac;
    logic [1:0]      cke;
    logic [1:0]      odt;
    logic            par;    // parity for the previous vector's command
    logic [3:0]      exp_cs;
    logic            exp_err;
  } vec_t;

  // R3 pair map {cs1,cs0,cs1,cs0}; R4 direct; R5/R6/R7/R8 via par/exp_err
  localparam vec_t VEC [NV] = '{
    '{1'b1, 4'b1110, 22'h000000, 2'b11, 2'b01, 1'b0, 4'b1010, 1'b1},
    '{1'b1, 4'b1111, 22'h000001, 2'b10, 2'b10, 1'b0, 4'b1111, 1'b1},
    '{1'b0, 4'b0111, 22'h000003, 2'b01, 2'b11, 1'b0, 4'b0111, 1'b1},
    '{1'b0, 4'b1011, 22'h3FFFFF, 2'b00, 2'b00, 1'b1, 4'b1011, 1'b0},
    '{1'b1, 4'b0011, 22'h000007, 2'b11, 2'b11, 1'b0, 4'b1111, 1'b1},
    '{1'b1, 4'b1101, 22'h000000, 2'b01, 2'b10, 1'b0, 4'b0101, 1'b1},
    '{1'b0, 4'b1111, 22'h000000, 2'b10, 2'b01, 1'b1, 4'b1111, 1'b0},
    '{1'b0, 4'b1111, 22'h000000, 2'b00, 2'b00, 1'b0, 4'b1111, 1'b1}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pair_mode = 1'b1;
  logic [AC_W-1:0] ac_in = '0;
  logic [1:0] cke_in = '0, odt_in = '0;
  logic [3:0] cs_n_in = 4'hF;
  logic par_in = 1'b0;
  logic [AC_W-1:0] ac_a, ac_b;
  logic [1:0] cke_a, cke_b, odt_a, odt_b;
  logic [3:0] cs_n_out;
  logic err_n;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  cmd_regbuf #(.AC_W(AC_W)) dut_i (
    .clk(clk), .rst(rst), .pair_mode(pair_mode), .ac_in(ac_in), .cke_in(cke_in),
    .odt_in(odt_in), .cs_n_in(cs_n_in), .par_in(par_in), .ac_a(ac_a), .ac_b(ac_b),
    .cke_a(cke_a), .cke_b(cke_b), .odt_a(odt_a), .odt_b(odt_b),
    .cs_n_out(cs_n_out), .err_n(err_n)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic drive(input logic m, input logic [3:0] cs, input logic [AC_W-1:0] ac,
                       input logic [1:0] ck, input logic [1:0] od, input logic p);
    pair_mode = m; cs_n_in = cs; ac_in = ac; cke_in = ck; odt_in = od; par_in = p;
  endtask

  initial begin
    repeat (2) @(negedge clk);
    check("R9 reset cs", 64'(cs_n_out), 64'hF);
    check("R9 reset cke", 64'({cke_a, cke_b}), 64'h0);
    check("R9 reset odt", 64'({odt_a, odt_b}), 64'h0);
    check("R9 reset ac", 64'(ac_a), 64'h0);
    check("R9 reset err", 64'(err_n), 64'h1);
    rst = 1'b0;
    drive(VEC[0].mode, VEC[0].cs, VEC[0].ac, VEC[0].cke, VEC[0].odt, VEC[0].par);
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      check("R1 ac_a", 64'(ac_a), 64'(VEC[i].ac));
      check("R2 ac_b", 64'(ac_b), 64'(VEC[i].ac));
      check("R1 R2 cke", 64'({cke_a, cke_b}), 64'({VEC[i].cke, VEC[i].cke}));
      check("R1 R2 odt", 64'({odt_a, odt_b}), 64'({odt_a == odt_b ? VEC[i].odt : 2'bxx, VEC[i].odt}));
      check(VEC[i].mode ? "R3 pair cs" : "R4 quad cs", 64'(cs_n_out), 64'(VEC[i].exp_cs));
      check("R5 R6 R7 R8 err", 64'(err_n), 64'(VEC[i].exp_err));
      if (i + 1 < NV)
        drive(VEC[i+1].mode, VEC[i+1].cs, VEC[i+1].ac, VEC[i+1].cke, VEC[i+1].odt, VEC[i+1].par);
    end
    // directed: selected command with parity 1, then reset lands with wrong parity
    drive(1'b1, 4'b1110, 22'h000001, 2'b11, 2'b11, 1'b0);
    @(negedge clk);
    rst = 1'b1;
    drive(1'b1, 4'b1111, 22'h000000, 2'b00, 2'b00, 1'b0);
    @(negedge clk);
    check("R9 mid reset err", 64'(err_n), 64'h1);
    check("R9 mid reset cs", 64'(cs_n_out), 64'hF);
    rst = 1'b0;
    drive(1'b1, 4'b1110, 22'h000001, 2'b00, 2'b00, 1'b0);
    @(negedge clk);
    check("R9 first compare suppressed", 64'(err_n), 64'h1);
    check("R1 after reset", 64'(ac_a), 64'h1);
    drive(1'b0, 4'b1110, 22'h000001, 2'b00, 2'b00, 1'b1);
    @(negedge clk);
    check("R5 match", 64'(err_n), 64'h1);
    drive(1'b0, 4'b1111, 22'h000000, 2'b00, 2'b00, 1'b0);
    @(negedge clk);
    check("R5 mismatch", 64'(err_n), 64'h0);
    drive(1'b0, 4'b1111, 22'h000000, 2'b00, 2'b00, 1'b0);
    @(negedge clk);
    check("R6 pulse ends", 64'(err_n), 64'h1);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(PERIOD * 5000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule